// File: doc/BRIEF.md
# System Clock Source Switcher

This block picks which one of up to eight clock sources feeds the system clock domain and turns a programmable post-divide ratio into a one-cycle clock-enable pulse. Software controls it through two 32-bit registers: a control register and a divider register. In the control register, software names a requested source and sets a self-clearing start bit. When the current output period ends, the block looks at the ready flag of that source. If the flag is set, the block moves to the source. If it is clear, the request is refused and the old source stays.

The divider register holds a target post-divide value. When the divider moves in a direction whose slew enable is set, the live divider walks toward the target in steps of a programmable size, with a fixed dwell time at each step. A busy flag stays set until the live value reaches the target. If slew is not enabled for that direction, the live divider jumps to the target on the next cycle. Source changes and divider wraps always occur on output period boundaries, so the enable stream never carries a shortened period.

Top module: `sysclk_switch`

## Requirements
- R1: After reset, source 0 is selected, and every register field reads 0: requested source, start bit, target divider, live divider, slew settings and busy.
- R2: The control register (address 0) layout is as follows. Bits [14:12] hold the current source and are read-only. Bits [10:8] hold the requested source. Bit 0 is the start bit. A write with bit 0 at 0 stores the requested field and does not start a switch.
- R3: A write with bit 0 at 1 makes bit 0 read 1 from the next cycle. The bit clears by itself at the end of the output period in progress, when the switch attempt completes.
- R4: A switch attempt whose requested source has its `src_ready` bit at 1 at completion changes the current-source field and `sel_src` to the requested source.
- R5: A switch attempt whose requested source has its `src_ready` bit at 0 at completion is refused. The current-source field and `sel_src` keep their old values.
- R6: `sel_src` changes only at an output period boundary. The first cycle on the new source is a cycle with `clk_en` high.
- R7: The divider register (address 1) holds the target divider in bits [23:20]. With live divider value D, `clk_en` is high for one cycle in every D+1 cycles, so D=0 keeps it high all the time.
- R8: The divider register reports busy in bit 0 and the live divider in bits [7:4], both read-only. Busy reads 1 whenever the live divider differs from the target.
- R9: When slew is not enabled for the direction of a change, the live divider equals the new target one cycle after the write.
- R10: Bit 2 of the divider register enables slewing when the target is below the live divider, which raises frequency. Bit 1 enables slewing when the target is above it. Bits [10:8] set the step size to the field value plus 1.
- R11: While slewing, the live divider moves by one step every HOLD_CYC cycles, and the first step comes HOLD_CYC cycles after the write. The last step is clamped to the target, and busy clears when the target is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 control, 1 divider |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 1 | Read address: 0 control, 1 divider |
| rd_data | output | DATA_W | Combinational read data |
| src_ready | input | NSRC | Per-source ready flags |
| sel_src | output | 3 | Currently selected source, drives the clock mux |
| clk_en | output | 1 | Divided clock-enable pulse |

## Verification
The bench targets requests to sources that are not ready. A design that got this wrong would move to a dead clock, or would leave the start bit stuck at 1. The bench also checks that a source change lands only on a cycle where `clk_en` is high. A design that switched mid-period would emit a short first period. In the slewing cases, the bench samples the live divider at the exact dwell cycles in both directions. An off-by-one dwell counter, an unclamped last step or a swapped direction enable would each show a wrong intermediate value or a busy flag that clears early. Divide ratios from 1 to 16 are measured by counting pulses over whole periods, which exposes a divider that counts one cycle too many or too few.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int SRC_W  = 3;
  localparam int DIV_W  = 4;
  localparam int STEP_W = 3;

  // control register fields
  localparam int CUR_LSB  = 12;
  localparam int REQ_LSB  = 8;
  localparam int SWEN_BIT = 0;

  // divider register fields
  localparam int TGT_LSB  = 20;
  localparam int STEP_LSB = 8;
  localparam int LIVE_LSB = 4;
  localparam int UP_BIT   = 2;
  localparam int DN_BIT   = 1;
  localparam int BUSY_BIT = 0;

  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_DIV  = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic              up_en;
    logic              dn_en;
    logic [STEP_W-1:0] step;
    logic [DIV_W-1:0]  tgt;
  } div_cfg_t;
endpackage

// File: rtl/sysclk_regs.sv
module sysclk_regs
  import sysclk_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sw_done,
  output logic [SRC_W-1:0]  req_src,
  output logic              sw_pend,
  output div_cfg_t          cfg,
  output logic              cfg_wr
);
  logic             ctrl_wr;
  logic [SRC_W-1:0] req_nxt;
  logic             pend_nxt;
  div_cfg_t         cfg_nxt;

  assign ctrl_wr = wr_en && (wr_addr == REG_CTRL);
  assign cfg_wr  = wr_en && (wr_addr == REG_DIV);

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[DATA_W-1:TGT_LSB+DIV_W],
                            wr_data[TGT_LSB-1:STEP_LSB+STEP_W],
                            wr_data[STEP_LSB-1:UP_BIT+1]};

  always_comb begin
    req_nxt  = req_src;
    pend_nxt = sw_pend;
    cfg_nxt  = cfg;
    if (sw_done) pend_nxt = 1'b0;
    if (ctrl_wr) begin
      req_nxt = wr_data[REQ_LSB +: SRC_W];
      if (wr_data[SWEN_BIT]) pend_nxt = 1'b1;
    end
    if (cfg_wr) begin
      cfg_nxt.tgt   = wr_data[TGT_LSB +: DIV_W];
      cfg_nxt.step  = wr_data[STEP_LSB +: STEP_W];
      cfg_nxt.up_en = wr_data[UP_BIT];
      cfg_nxt.dn_en = wr_data[DN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_src <= '0;
      sw_pend <= 1'b0;
      cfg     <= '0;
    end else begin
      req_src <= req_nxt;
      sw_pend <= pend_nxt;
      cfg     <= cfg_nxt;
    end
  end
endmodule

// File: rtl/sysclk_divcnt.sv
module sysclk_divcnt
  import sysclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] live_div,
  output logic             clk_en,
  output logic             period_end
);
  logic [DIV_W-1:0] cnt, cnt_nxt;

  assign period_end = (cnt >= live_div);
  assign clk_en     = (cnt == '0);

  always_comb begin
    cnt_nxt = period_end ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/sysclk_srcsel.sv
module sysclk_srcsel
  import sysclk_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_pend,
  input  logic [SRC_W-1:0] req_src,
  input  logic             period_end,
  input  logic [NSRC-1:0]  src_ready,
  output logic [SRC_W-1:0] cur_src,
  output logic             sw_done
);
  localparam int NSLOT = 1 << SRC_W;

  logic [NSLOT-1:0] rdy_full;
  logic [SRC_W-1:0] cur_nxt;

  // slots past the implemented sources are never ready
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    if (g < NSRC) begin : g_real
      assign rdy_full[g] = src_ready[g];
    end else begin : g_absent
      assign rdy_full[g] = 1'b0;
    end
  end

  assign sw_done = sw_pend && period_end;

  always_comb begin
    cur_nxt = cur_src;
    if (sw_done && rdy_full[req_src]) cur_nxt = req_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_src <= '0;
    else        cur_src <= cur_nxt;
  end
endmodule

// File: rtl/sysclk_divslew.sv
module sysclk_divslew
  import sysclk_pkg::*;
#(
  parameter int HOLD_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  div_cfg_t         cfg,
  input  logic             cfg_wr,
  output logic [DIV_W-1:0] live_div,
  output logic             busy
);
  localparam int HOLD_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam int CMP_W  = ((DIV_W > STEP_W + 1) ? DIV_W : STEP_W + 1) + 1;

  logic [HOLD_W-1:0] hold, hold_nxt;
  logic [DIV_W-1:0]  live_nxt;
  logic              freq_up, slew_on, hold_done;
  logic [CMP_W-1:0]  gap, step_sz, live_w, tgt_w;

  assign busy      = (live_div != cfg.tgt);
  assign freq_up   = (cfg.tgt < live_div);
  assign slew_on   = freq_up ? cfg.up_en : cfg.dn_en;
  assign hold_done = (hold == HOLD_W'(HOLD_CYC - 1));
  assign live_w    = CMP_W'(live_div);
  assign tgt_w     = CMP_W'(cfg.tgt);
  assign step_sz   = CMP_W'(cfg.step) + 1'b1;
  assign gap       = freq_up ? (live_w - tgt_w) : (tgt_w - live_w);

  always_comb begin
    live_nxt = live_div;
    hold_nxt = '0;
    if (cfg_wr || !busy) begin
      hold_nxt = '0;
    end else if (!slew_on) begin
      live_nxt = cfg.tgt;
    end else if (hold_done) begin
      if (gap > step_sz)
        live_nxt = freq_up ? DIV_W'(live_w - step_sz) : DIV_W'(live_w + step_sz);
      else
        live_nxt = cfg.tgt;
    end else begin
      hold_nxt = hold + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_div <= '0;
      hold     <= '0;
    end else begin
      live_div <= live_nxt;
      hold     <= hold_nxt;
    end
  end
endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch
  import sysclk_pkg::*;
#(
  parameter int NSRC     = 8,
  parameter int HOLD_CYC = 4,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NSRC-1:0]   src_ready,
  output logic [SRC_W-1:0]  sel_src,
  output logic              clk_en
);
  logic [SRC_W-1:0] req_src;
  logic             sw_pend, sw_done, cfg_wr, period_end, busy;
  div_cfg_t         cfg;
  logic [DIV_W-1:0] live_div;

  sysclk_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sw_done(sw_done), .req_src(req_src),
    .sw_pend(sw_pend), .cfg(cfg), .cfg_wr(cfg_wr)
  );

  sysclk_srcsel #(.NSRC(NSRC)) u_srcsel (
    .clk(clk), .rst_n(rst_n), .sw_pend(sw_pend), .req_src(req_src),
    .period_end(period_end), .src_ready(src_ready),
    .cur_src(sel_src), .sw_done(sw_done)
  );

  sysclk_divslew #(.HOLD_CYC(HOLD_CYC)) u_slew (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .cfg_wr(cfg_wr),
    .live_div(live_div), .busy(busy)
  );

  sysclk_divcnt u_cnt (
    .clk(clk), .rst_n(rst_n), .live_div(live_div),
    .clk_en(clk_en), .period_end(period_end)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == REG_CTRL) begin
      rd_data[CUR_LSB +: SRC_W] = sel_src;
      rd_data[REQ_LSB +: SRC_W] = req_src;
      rd_data[SWEN_BIT]         = sw_pend;
    end else begin
      rd_data[TGT_LSB +: DIV_W]   = cfg.tgt;
      rd_data[STEP_LSB +: STEP_W] = cfg.step;
      rd_data[LIVE_LSB +: DIV_W]  = live_div;
      rd_data[UP_BIT]             = cfg.up_en;
      rd_data[DN_BIT]             = cfg.dn_en;
      rd_data[BUSY_BIT]           = busy;
    end
  end
endmodule

// File: rtl/sysclk_switch_chk.sv
module sysclk_switch_chk
  import sysclk_pkg::*;
#(
  parameter int NSRC = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SRC_W-1:0]  sel_src,
  input logic              clk_en,
  input logic [NSRC-1:0]   src_ready,
  input logic              period_end,
  input logic              sw_pend,
  input logic [SRC_W-1:0]  req_src,
  input logic [DIV_W-1:0]  live_div,
  input logic [DIV_W-1:0]  tgt_div,
  input logic [STEP_W-1:0] step,
  input logic              up_en,
  input logic              dn_en
);
  logic [NSRC-1:0]  rdy_q;
  logic [DIV_W-1:0] live_q;
  logic [DIV_W:0]   moved;
  logic             slewing;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= '0;
      live_q <= '0;
    end else begin
      rdy_q  <= src_ready;
      live_q <= live_div;
    end
  end

  assign moved   = (live_div > live_q) ? (DIV_W+1)'(live_div - live_q)
                                       : (DIV_W+1)'(live_q - live_div);
  assign slewing = (tgt_div != live_div) && ((tgt_div < live_div) ? up_en : dn_en);

  // R3
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_pend && period_end |=> !sw_pend);

  // R4
  ready_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_src != $past(sel_src)) |-> rdy_q[sel_src]);

  // R5
  refuse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_pend && period_end && !src_ready[req_src] |=> $stable(sel_src));

  // R6
  boundary_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_src != $past(sel_src)) |-> (clk_en && $past(period_end)));

  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && (live_div != '0) |=> !clk_en);

  // R11
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(slewing) && (live_div != live_q) |-> (moved <= (DIV_W+1)'($past(step)) + 1'b1));
endmodule

bind sysclk_switch sysclk_switch_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_src(sel_src), .clk_en(clk_en),
  .src_ready(src_ready), .period_end(period_end), .sw_pend(sw_pend),
  .req_src(req_src), .live_div(live_div), .tgt_div(cfg.tgt),
  .step(cfg.step), .up_en(cfg.up_en), .dn_en(cfg.dn_en)
);

// File: tb/sim_sysclk_switch.sv
module sim_sysclk_switch;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 4;
  localparam int NSRC       = 8;

  // {ready[7:0], requested[2:0], expected current[2:0]}
  localparam logic [13:0] SW_TAB [8] = '{
    {8'hFF, 3'd3, 3'd3},
    {8'h01, 3'd5, 3'd3},
    {8'h20, 3'd5, 3'd5},
    {8'h20, 3'd0, 3'd5},
    {8'h80, 3'd7, 3'd7},
    {8'h01, 3'd0, 3'd0},
    {8'h10, 3'd4, 3'd4},
    {8'h10, 3'd4, 3'd4}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [NSRC-1:0] src_ready;
  logic [2:0]  sel_src;
  logic        clk_en;

  int n_chk  = 0;
  int n_fail = 0;
  logic [2:0]  prev_sel;
  logic [31:0] v;

  sysclk_switch #(.NSRC(NSRC), .HOLD_CYC(HOLD), .DATA_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .src_ready(src_ready), .sel_src(sel_src), .clk_en(clk_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_start_clear(output logic cleared);
    logic [31:0] r;
    cleared = 1'b0;
    for (int i = 0; i < 64; i++) begin
      rd(1'b0, r);
      if (!r[0]) begin
        cleared = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  // R6: a source change is seen only in a cycle where clk_en is high
  always @(negedge clk) begin
    if (rst_n === 1'b1 && sel_src !== prev_sel)
      chk("R6 clk_en on source change", {31'd0, clk_en}, 32'd1);
    prev_sel = sel_src;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic done;
    int   cnt;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;
    rd_addr = 1'b0; src_ready = '0; prev_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, v); chk("R1 control reg", v, 32'h0);
    rd(1'b1, v); chk("R1 divider reg", v, 32'h0);
    chk("R1 sel_src", {29'd0, sel_src}, 32'd0);
    chk("R1 clk_en at divide by 1", {31'd0, clk_en}, 32'd1);

    // R7 divide ratios, counted over six whole periods
    foreach (SW_TAB[k]) begin end
    for (int d = 0; d < 16; d += 5) begin
      wr(1'b1, 32'(d) << 20);
      repeat (2) @(negedge clk);
      cnt = 0;
      for (int c = 0; c < (d + 1) * 6; c++) begin
        if (clk_en) cnt++;
        @(negedge clk);
      end
      chk($sformatf("R7 pulses at ratio %0d", d + 1), 32'(cnt), 32'd6);
    end

    // table of switch attempts at divider 5
    wr(1'b1, 32'd5 << 20);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      src_ready = SW_TAB[i][13:6];
      wr(1'b0, (32'(SW_TAB[i][5:3]) << 8) | 32'd1);
      rd(1'b0, v);
      chk("R3 start bit set after write", {31'd0, v[0]}, 32'd1);
      wait_start_clear(done);
      chk("R3 start bit clears", {31'd0, done}, 32'd1);
      rd(1'b0, v);
      chk(SW_TAB[i][13:6][SW_TAB[i][5:3]] ? "R4 accepted switch" : "R5 refused switch",
          {29'd0, v[14:12]}, {29'd0, SW_TAB[i][2:0]});
      chk("R4 sel_src matches field", {29'd0, sel_src}, {29'd0, SW_TAB[i][2:0]});
    end

    // R2 write without start bit only stores the request
    src_ready = 8'hFF;
    wr(1'b0, 32'd6 << 8);
    repeat (20) @(negedge clk);
    rd(1'b0, v);
    chk("R2 requested field stored", {29'd0, v[10:8]}, 32'd6);
    chk("R2 no switch without start bit", {29'd0, v[14:12]}, 32'd4);

    // R9 immediate change, then R10/R11 downward slew 0 -> 7, step 2
    wr(1'b1, 32'd0);
    @(negedge clk);
    rd(1'b1, v);
    chk("R9 live divider jumps", {28'd0, v[7:4]}, 32'd0);
    wr(1'b1, (32'd7 << 20) | (32'd1 << 8) | 32'h2);
    rd(1'b1, v);
    chk("R8 busy during slew", {31'd0, v[0]}, 32'd1);
    chk("R11 no step before dwell", {28'd0, v[7:4]}, 32'd0);
    repeat (HOLD) @(negedge clk);
    rd(1'b1, v);
    chk("R11 first step", {28'd0, v[7:4]}, 32'd2);
    repeat (HOLD) @(negedge clk);
    rd(1'b1, v);
    chk("R11 second step", {28'd0, v[7:4]}, 32'd4);
    repeat (2 * HOLD - 1) @(negedge clk);
    rd(1'b1, v);
    chk("R11 third step", {28'd0, v[7:4]}, 32'd6);
    chk("R8 busy before target", {31'd0, v[0]}, 32'd1);
    @(negedge clk);
    rd(1'b1, v);
    chk("R11 clamped last step", {28'd0, v[7:4]}, 32'd7);
    chk("R11 busy clears at target", {31'd0, v[0]}, 32'd0);

    // R10 upward slew 7 -> 1, step 3
    wr(1'b1, (32'd1 << 20) | (32'd2 << 8) | 32'h4);
    repeat (HOLD) @(negedge clk);
    rd(1'b1, v);
    chk("R10 upward step of 3", {28'd0, v[7:4]}, 32'd4);
    repeat (HOLD) @(negedge clk);
    rd(1'b1, v);
    chk("R10 upward clamp", {28'd0, v[7:4]}, 32'd1);
    chk("R10 busy clear", {31'd0, v[0]}, 32'd0);

    // R9/R10 only the upward enable set, divider increases: no slew
    wr(1'b1, (32'd9 << 20) | (32'd0 << 8) | 32'h4);
    rd(1'b1, v);
    chk("R8 busy for one cycle", {31'd0, v[0]}, 32'd1);
    @(negedge clk);
    rd(1'b1, v);
    chk("R9 jump when direction not slewed", {28'd0, v[7:4]}, 32'd9);
    chk("R9 busy clear after jump", {31'd0, v[0]}, 32'd0);

    finish_run();
  end
endmodule